// File: doc/BRIEF.md
# Bounded-range repeating binary counter

This block is a small synchronous counter that steps through the codes 2 to 14 without a break on a free-running clock. After 14 it goes back to 2, and the cycle repeats. Internally it is a plain binary up-counter with a synchronous parallel load and an asynchronous clear. A terminal-count decoder watches the counter value. When the counter reaches the last code of the range, the decoder asserts the load, and the next clock edge writes the start code back.

The codes outside the range are 0, 1 and 15. Each has a defined next state, and every one of them rejoins the main loop within two clock edges. The clear is asynchronous and active low, and it drives the counter to 0. From 0 the counter moves up through 1 and then into the range.

A synchronous test load lets a bench or a scan-style controller place any code in the counter. This is the only way to reach 15, which the counter never enters by itself. The start code, the stop code and the counter width are parameters, and they are checked when the design is elaborated.

Top module: `bounded_counter`

## Requirements
- R1: When the count holds a value from 2 to 13 and the test load is low, the next rising clock edge raises the count by exactly one.
- R2: When the count is 14 and the test load is low, the next rising clock edge loads 2. This wrap happens with clr_n held high, so it does not use the clear.
- R3: While clr_n is low, the count is 0. It becomes 0 as soon as clr_n falls, without waiting for a clock edge, and it stays 0 while clr_n stays low.
- R4: When the count is 15 and the test load is low, the next rising clock edge loads 2.
- R5: When the count is 0 and the test load is low, the next rising clock edge gives 1. When the count is 1, the next edge gives 2.
- R6: When tst_load is high at a rising clock edge, the count takes tst_value. This takes priority over counting and over the wrap load.
- R7: Once the count is in the range, it returns to 2 every 13 clock edges, and it passes through 13 distinct codes in each period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock; the counter changes on its rising edge |
| clr_n | input | 1 | Asynchronous clear, active low; forces the count to 0 |
| tst_load | input | 1 | Synchronous test load enable |
| tst_value | input | 4 | Code written into the counter when tst_load is high |
| count | output | 4 | Present counter value |

## Verification
The hardest state to reach is code 15. The counter never enters it on its own, and the clear only reaches 0. The stimulus therefore uses the test load to write 15, 0, 1 and 14 at chosen cycles, then releases the load and lets the counter recover under the clock. A behavioural reference model is compared with the count at every cycle. Directed checks cover three further cases:
- a clear dropped halfway through a clock period,
- a test load that collides with the terminal count,
- the measured length of one full period.

// File: rtl/bounded_counter_pkg.sv
package bounded_counter_pkg;

   // Decoder variants chosen at elaboration time.
   typedef enum logic [0:0] {
      DEC_EQUAL = 1'b0,   // stop code is the top code: no unused high codes
      DEC_RANGE = 1'b1    // codes above the stop code also request a load
   } dec_kind_e;

   function automatic int unsigned top_code(input int unsigned width);
      return (1 << width) - 1;
   endfunction

   function automatic dec_kind_e pick_decoder(input int unsigned width,
                                              input int unsigned stop);
      return (stop == top_code(width)) ? DEC_EQUAL : DEC_RANGE;
   endfunction

endpackage

// File: rtl/bc_incrementer.sv
module bc_incrementer #(
   parameter int unsigned WIDTH = 4
) (
   input  logic [WIDTH-1:0] val_i,
   output logic [WIDTH-1:0] inc_o
);

   // carry[i] is high when every bit below bit i is set.
   logic [WIDTH:0] carry;

   assign carry[0] = 1'b1;

   genvar gi;
   generate
      for (gi = 0; gi < WIDTH; gi++) begin : g_bit
         assign inc_o[gi]    = val_i[gi] ^ carry[gi];
         assign carry[gi+1]  = carry[gi] & val_i[gi];
      end
   endgenerate

endmodule

// File: rtl/bc_term_decode.sv
module bc_term_decode
   import bounded_counter_pkg::*;
#(
   parameter int unsigned WIDTH = 4,
   parameter int unsigned STOP  = 14
) (
   input  logic [WIDTH-1:0] cnt_i,
   output logic             wrap_o
);

   localparam dec_kind_e          KIND     = pick_decoder(WIDTH, STOP);
   localparam logic [WIDTH-1:0]   STOP_VAL = WIDTH'(STOP);

   generate
      if (KIND == DEC_EQUAL) begin : g_equal
         // No code lies above the stop code, so a match on it is enough.
         assign wrap_o = (cnt_i == STOP_VAL);
      end else begin : g_range
         // The stop code and every unused code above it request the load.
         assign wrap_o = (cnt_i >= STOP_VAL);
      end
   endgenerate

endmodule

// File: rtl/bc_core.sv
module bc_core #(
   parameter int unsigned WIDTH = 4
) (
   input  logic             clk,
   input  logic             clr_n,
   input  logic             load_i,
   input  logic [WIDTH-1:0] load_val_i,
   output logic [WIDTH-1:0] q_o
);

   logic [WIDTH-1:0] q_r;
   logic [WIDTH-1:0] q_inc;

   bc_incrementer #(.WIDTH(WIDTH)) u_inc (
      .val_i (q_r),
      .inc_o (q_inc)
   );

   always_ff @(posedge clk or negedge clr_n) begin
      if (!clr_n)
         q_r <= '0;
      else if (load_i)
         q_r <= load_val_i;
      else
         q_r <= q_inc;
   end

   assign q_o = q_r;

endmodule

// File: rtl/bounded_counter.sv
module bounded_counter
   import bounded_counter_pkg::*;
#(
   parameter int unsigned WIDTH = 4,
   parameter int unsigned START = 2,
   parameter int unsigned STOP  = 14
) (
   input  logic             clk,
   input  logic             clr_n,
   input  logic             tst_load,
   input  logic [WIDTH-1:0] tst_value,
   output logic [WIDTH-1:0] count
);

   localparam logic [WIDTH-1:0] START_VAL = WIDTH'(START);
   localparam logic [WIDTH-1:0] STOP_VAL  = WIDTH'(STOP);

   // Elaboration-time parameter checks.
   generate
      if (WIDTH < 2) begin : g_bad_width
         $error("bounded_counter: WIDTH must be at least 2");
      end
      if (START >= STOP) begin : g_bad_order
         $error("bounded_counter: START must be below STOP");
      end
      if (STOP > top_code(WIDTH)) begin : g_bad_stop
         $error("bounded_counter: STOP does not fit in WIDTH bits");
      end
   endgenerate

   logic             wrap;
   logic             load;
   logic [WIDTH-1:0] load_val;

   bc_term_decode #(.WIDTH(WIDTH), .STOP(STOP)) u_dec (
      .cnt_i  (count),
      .wrap_o (wrap)
   );

   // The test load has priority over the wrap load.
   assign load     = tst_load | wrap;
   assign load_val = tst_load ? tst_value : START_VAL;

   bc_core #(.WIDTH(WIDTH)) u_core (
      .clk        (clk),
      .clr_n      (clr_n),
      .load_i     (load),
      .load_val_i (load_val),
      .q_o        (count)
   );

   AST_IN_RANGE_STEP: assert property (@(posedge clk) disable iff (!clr_n)
      (!tst_load && count >= START_VAL && count < STOP_VAL)
      |=> (count == $past(count) + 1'b1)); // R1

   AST_WRAP_TO_START: assert property (@(posedge clk) disable iff (!clr_n)
      (!tst_load && count == STOP_VAL) |=> (count == START_VAL)); // R2

   AST_HIGH_RECOVER: assert property (@(posedge clk) disable iff (!clr_n)
      (!tst_load && count > STOP_VAL) |=> (count == START_VAL)); // R4

   AST_LOW_RECOVER: assert property (@(posedge clk) disable iff (!clr_n)
      (!tst_load && count < START_VAL) |=> (count == $past(count) + 1'b1)); // R5

   AST_TEST_LOAD: assert property (@(posedge clk) disable iff (!clr_n)
      tst_load |=> (count == $past(tst_value))); // R6

endmodule

// File: tb/bounded_counter_bench.sv
module bounded_counter_bench;

   logic       clk = 1'b0;
   logic       clr_n = 1'b0;
   logic       tst_load = 1'b0;
   logic [3:0] tst_value = 4'd0;
   logic [3:0] count;

   int total = 0;
   int bad   = 0;
   int model = 0;
   int n;
   int seen_mask;
   bit done = 1'b0;
   bit track = 1'b0;
   string tag = "R3";

   always #2 clk = ~clk;

   bounded_counter u_bounded_counter (
      .clk       (clk),
      .clr_n     (clr_n),
      .tst_load  (tst_load),
      .tst_value (tst_value),
      .count     (count)
   );

   task automatic check(input string req, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s: count=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   // Behavioural reference: the range is 2..14, and every other code heads toward 2.
   always @(posedge clk or negedge clr_n) begin
      if (!clr_n) begin
         model <= 0;
         tag   <= "R3";
      end else if (tst_load) begin
         model <= int'(tst_value);
         tag   <= "R6";
      end else if (model == 14) begin
         model <= 2;
         tag   <= "R2";
      end else if (model > 14) begin
         model <= 2;
         tag   <= "R4";
      end else if (model < 2) begin
         model <= model + 1;
         tag   <= "R5";
      end else begin
         model <= model + 1;
         tag   <= "R1";
      end
   end

   always @(negedge clk) begin
      if (track && clr_n) check(tag, int'(count), model);
   end

   task automatic force_code(input int v);
      tst_load  = 1'b1;
      tst_value = 4'(v);
      @(negedge clk);
      tst_load  = 1'b0;
   endtask

   initial begin
      #1;
      check("R3", int'(count), 0);              // value with the clear held low
      @(negedge clk);
      @(negedge clk);
      check("R3", int'(count), 0);              // stays 0 while clr_n is low
      clr_n = 1'b1;
      track = 1'b1;
      @(negedge clk);
      check("R5", int'(count), 1);              // 0 -> 1
      @(negedge clk);
      check("R5", int'(count), 2);              // 1 -> 2
      repeat (30) @(negedge clk);

      // R7: measure one full period and count distinct codes.
      while (count != 4'd2) @(negedge clk);
      n = 0;
      seen_mask = 0;
      do begin
         seen_mask |= (1 << count);
         @(negedge clk);
         n++;
      end while (count != 4'd2 && n < 40);
      check("R7", n, 13);
      check("R7", $countones(seen_mask), 13);

      // Recovery paths from the unused codes.
      force_code(15);
      check("R4", int'(count), 15);
      @(negedge clk);
      check("R4", int'(count), 2);
      force_code(0);
      @(negedge clk);
      check("R5", int'(count), 1);
      @(negedge clk);
      check("R5", int'(count), 2);
      force_code(1);
      @(negedge clk);
      check("R5", int'(count), 2);
      force_code(14);
      @(negedge clk);
      check("R2", int'(count), 2);
      check("R2", int'(clr_n), 1);

      // R6: the test load collides with the terminal count.
      force_code(14);
      force_code(7);
      check("R6", int'(count), 7);
      repeat (5) @(negedge clk);

      // R3: the clear drops halfway through a clock period.
      #1 clr_n = 1'b0;
      #0.5;
      check("R3", int'(count), 0);
      repeat (2) @(negedge clk);
      check("R3", int'(count), 0);
      clr_n = 1'b1;
      repeat (20) @(negedge clk);

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog: count=%0d expected=finished", count);
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule